// File: doc/BRIEF.md
# Threshold-Voting Latin-Square Word Corrector

This block repairs a 64-bit data word protected by an orthogonal Latin-square code with eight lines per square and double-error strength. The code has four groups of eight parity lines, 32 check positions in all. When a part is set up, any subset of those lines may be switched off. Only the check bits of the lines still on are stored, packed together at the low end of a 32-bit check field. The corrector takes three inputs: the received data word, that packed field, and a 32-bit line-enable vector. Its output is the repaired word.

Inside, the packed field is first spread back onto its full check positions. Each line then gives a parity sum. Every data bit collects one vote from itself and one vote from each line that covers it, and a line's vote is gated by that line's enable bit. The decision threshold follows how many votes are actually enabled for that bit, so the same logic works for the full code and for every reduced code. The decision is combinational. A parameter selects whether it is registered before the output.

Top module: `ols_tv_decoder`

## Requirements
- R1: Data bit i sits at row r = i / 8 and column c = i mod 8. Group 0 places it on line r, group 1 on line c, group 2 on line r XOR c, and group 3 on line r XOR (2·c), where the product is taken in GF(8) with polynomial x^3+x+1. The full check bit 8·g + line is the even parity (XOR) of the data bits on that line.
- R2: Bit j of row_en_i enables full check position j. Packed bit k carries the check bit of the k-th enabled position, counting upward from position 0. Packed bits at or above the number of enabled positions have no effect on the output.
- R3: Each bit receives one estimate from its own received value. Each enabled line covering the bit adds one more estimate: that line's check bit XORed with every other data bit on the line. Disabled lines add nothing.
- R4: A bit's output is 1 when more than half of its counted estimates are 1 and 0 when fewer than half are. When exactly half are 1, the output is the received bit.
- R5: With all 32 lines enabled, any zero, one or two flipped bits anywhere in the data or check fields give back the original data word.
- R6: With any one full group of eight lines disabled, any single flipped bit in the data or the stored check bits gives back the original data word. This includes the case where a middle group is disabled, so later check bits are packed down.
- R7: With every line disabled, the output equals the received data word.
- R8: When only group 0 is enabled, every bit ties or agrees with itself, so the output equals the received data word even if a stored check bit is wrong.
- R9: With the default output register, synchronous active-high reset drives the output to zero. Otherwise the output shows the decision for the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| data_i | input | 64 | Received data word |
| pchk_i | input | 32 | Packed check bits of the enabled lines |
| row_en_i | input | 32 | Enable per full check position |
| corr_o | output | 64 | Corrected data word |

## Verification
The hardest behaviour to reach from the ports is packing when the enable vector has gaps. A check bit belonging to a late group has to be read from a lower packed slot, and the unused high slots must be ignored. The stimulus reaches this by disabling a middle group, filling the unused packed bits with random values, and injecting single errors. The even-tie rule is reached by leaving only one group enabled and flipping a stored check bit, which gives each affected bit one vote each way.

// File: rtl/ols_pkg.sv
package ols_pkg;

    localparam int unsigned M_LOG = 3;
    localparam int unsigned M     = 1 << M_LOG;
    localparam int unsigned T     = 2;
    localparam int unsigned NGRP  = 2 * T;
    localparam int unsigned NDATA = M * M;
    localparam int unsigned NCHK  = NGRP * M;
    localparam int unsigned CNT_W = $clog2(NGRP + 2);
    localparam logic [M_LOG:0] POLY = 4'b1011;

    typedef logic [NDATA-1:0] data_t;
    typedef logic [NCHK-1:0]  chk_t;

    typedef struct packed {
        logic [CNT_W-1:0] ones;
        logic [CNT_W-1:0] total;
    } tally_t;

    // multiply in GF(2^M_LOG)
    function automatic logic [M_LOG-1:0] gf_mul(input logic [M_LOG-1:0] a,
                                                 input logic [M_LOG-1:0] b);
        logic [M_LOG-1:0] p;
        logic [M_LOG-1:0] x;
        p = '0;
        x = a;
        for (int k = 0; k < int'(M_LOG); k++) begin
            if (b[k]) p = p ^ x;
            if (x[M_LOG-1]) x = (x << 1) ^ POLY[M_LOG-1:0];
            else            x = x << 1;
        end
        return p;
    endfunction

    // line of group g that covers data bit i
    function automatic int unsigned line_of(input int unsigned g, input int unsigned i);
        int unsigned r;
        int unsigned c;
        r = i / M;
        c = i % M;
        if (g == 0)      return r;
        else if (g == 1) return c;
        else return r ^ int'(gf_mul(M_LOG'(g - 1), M_LOG'(c)));
    endfunction

    // data bits on full check position j
    function automatic data_t line_mask(input int unsigned j);
        data_t mk;
        mk = '0;
        for (int unsigned i = 0; i < NDATA; i++)
            if (line_of(j / M, i) == (j % M)) mk[i] = 1'b1;
        return mk;
    endfunction

endpackage

// File: rtl/ols_chk_expand.sv
module ols_chk_expand
    import ols_pkg::*;
(
    input  chk_t en_i,
    input  chk_t packed_i,
    output chk_t full_o
);
    localparam int unsigned IDX_W = $clog2(NCHK);

    logic [IDX_W:0] idx;

    always_comb begin
        full_o = '0;
        idx    = '0;
        for (int j = 0; j < int'(NCHK); j++) begin
            if (en_i[j]) begin
                full_o[j] = packed_i[idx[IDX_W-1:0]];
                idx       = idx + (IDX_W+1)'(1);
            end
        end
    end
endmodule

// File: rtl/ols_row_parity.sv
module ols_row_parity
    import ols_pkg::*;
(
    input  data_t data_i,
    input  chk_t  full_i,
    output chk_t  par_o
);
    for (genvar j = 0; j < int'(NCHK); j++) begin : g_line
        localparam data_t MASK = line_mask(j);
        assign par_o[j] = full_i[j] ^ (^(data_i & MASK));
    end
endmodule

// File: rtl/ols_vote_cell.sv
module ols_vote_cell
    import ols_pkg::*;
(
    input  logic            rx_i,
    input  logic [NGRP-1:0] est_i,
    input  logic [NGRP-1:0] ena_i,
    output logic            bit_o
);
    tally_t t;

    always_comb begin
        t.ones  = CNT_W'(rx_i) + CNT_W'($countones(est_i));
        t.total = CNT_W'(1) + CNT_W'($countones(ena_i));
        if ({t.ones, 1'b0} > {1'b0, t.total})       bit_o = 1'b1;
        else if ({t.ones, 1'b0} == {1'b0, t.total}) bit_o = rx_i;
        else                                        bit_o = 1'b0;
    end
endmodule

// File: rtl/ols_tv_decoder.sv
module ols_tv_decoder
    import ols_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NDATA-1:0] data_i,
    input  logic [NCHK-1:0]  pchk_i,
    input  logic [NCHK-1:0]  row_en_i,
    output logic [NDATA-1:0] corr_o
);
    chk_t  full_chk;
    chk_t  line_par;
    data_t fixed;

    ols_chk_expand u_expand (
        .en_i     (row_en_i),
        .packed_i (pchk_i),
        .full_o   (full_chk)
    );

    ols_row_parity u_par (
        .data_i (data_i),
        .full_i (full_chk),
        .par_o  (line_par)
    );

    for (genvar gi = 0; gi < int'(NDATA); gi++) begin : g_bit
        logic [NGRP-1:0] est_w;
        logic [NGRP-1:0] ena_w;
        for (genvar gg = 0; gg < int'(NGRP); gg++) begin : g_est
            localparam int unsigned J = gg * M + line_of(gg, gi);
            assign ena_w[gg] = row_en_i[J];
            assign est_w[gg] = row_en_i[J] & (line_par[J] ^ data_i[gi]);
        end
        ols_vote_cell u_cell (
            .rx_i  (data_i[gi]),
            .est_i (est_w),
            .ena_i (ena_w),
            .bit_o (fixed[gi])
        );
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) corr_o <= '0;
            else     corr_o <= fixed;
        end
    end else begin : g_comb
        assign corr_o = fixed;
    end
endmodule

// File: rtl/ols_tv_decoder_chk.sv
module ols_tv_decoder_chk
    import ols_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic [NDATA-1:0] data_i,
    input logic [NCHK-1:0]  pchk_i,
    input logic [NCHK-1:0]  row_en_i,
    input logic [NDATA-1:0] corr_o
);
    localparam chk_t OTHER_GRPS = ~chk_t'((1 << M) - 1);

    if (OUT_REG) begin : g_seq
        // R9
        reset_clear_chk: assert property (@(posedge clk) rst |=> corr_o == '0);
        // R7
        all_off_pass_chk: assert property (@(posedge clk) disable iff (rst)
            (row_en_i == '0) |=> (corr_o == $past(data_i)));
        // R8
        grp0_only_pass_chk: assert property (@(posedge clk) disable iff (rst)
            ((row_en_i & OTHER_GRPS) == '0) |=> (corr_o == $past(data_i)));
        // R9
        steady_out_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $stable(data_i) && $stable(pchk_i) && $stable(row_en_i))
            |=> $stable(corr_o));
    end else begin : g_cmb
        // R7
        all_off_pass_chk: assert property (@(posedge clk) disable iff (rst)
            (row_en_i == '0) |-> (corr_o == data_i));
        // R8
        grp0_only_pass_chk: assert property (@(posedge clk) disable iff (rst)
            ((row_en_i & OTHER_GRPS) == '0) |-> (corr_o == data_i));
        // R9
        steady_out_chk: assert property (@(posedge clk) disable iff (rst)
            ($stable(data_i) && $stable(pchk_i) && $stable(row_en_i)) |-> $stable(corr_o));
    end
endmodule

bind ols_tv_decoder ols_tv_decoder_chk #(.OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/ols_tv_decoder_test.sv
`timescale 1ns/1ps
module ols_tv_decoder_test;
    import ols_pkg::*;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    data_t data_s = '0;
    chk_t  pk_s = '0;
    chk_t  en_s = '0;
    data_t corr_s;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    always #5 clk = ~clk;

    ols_tv_decoder uut (
        .clk(clk), .rst(rst), .data_i(data_s), .pchk_i(pk_s),
        .row_en_i(en_s), .corr_o(corr_s)
    );

    function automatic int b_gmul(int a, int b);
        int p = 0;
        int x = a;
        for (int k = 0; k < 3; k++) begin
            if (((b >> k) & 1) == 1) p = p ^ x;
            x = x << 1;
            if ((x & 8) != 0) x = x ^ 11;
        end
        return p;
    endfunction

    // R1 line numbering
    function automatic int b_line(int g, int i);
        int r = i / 8;
        int c = i % 8;
        if (g == 0) return r;
        if (g == 1) return c;
        return r ^ b_gmul(g - 1, c);
    endfunction

    function automatic chk_t b_encode(data_t d);
        chk_t ck = '0;
        for (int g = 0; g < 4; g++)
            for (int i = 0; i < 64; i++)
                if (d[i]) ck[g*8 + b_line(g, i)] = ~ck[g*8 + b_line(g, i)];
        return ck;
    endfunction

    // R2 packing, junk fills unused slots
    function automatic chk_t b_pack(chk_t full, chk_t en, chk_t junk);
        chk_t p = junk;
        int k = 0;
        for (int j = 0; j < 32; j++)
            if (en[j]) begin p[k] = full[j]; k++; end
        return p;
    endfunction

    // R3 and R4 reference vote
    function automatic data_t b_decode(data_t d, chk_t pk, chk_t en);
        chk_t  full = '0;
        data_t o;
        int k = 0;
        for (int j = 0; j < 32; j++)
            if (en[j]) begin full[j] = pk[k]; k++; end
        for (int i = 0; i < 64; i++) begin
            int ones = int'(d[i]);
            int tot = 1;
            for (int g = 0; g < 4; g++) begin
                int j = g*8 + b_line(g, i);
                if (en[j]) begin
                    logic est = full[j];
                    for (int q = 0; q < 64; q++)
                        if (q != i && b_line(g, q) == b_line(g, i)) est = est ^ d[q];
                    tot++;
                    ones += int'(est);
                end
            end
            if (2*ones > tot)       o[i] = 1'b1;
            else if (2*ones == tot) o[i] = d[i];
            else                    o[i] = 1'b0;
        end
        return o;
    endfunction

    function automatic data_t rnd_data();
        return {$urandom(), $urandom()};
    endfunction

    task automatic check(string tag, data_t act, data_t exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at falling edge, result registered at rising edge, sample next falling edge
    task automatic run_vec(data_t d, chk_t pk, chk_t en, string tag);
        data_t ref_o = b_decode(d, pk, en);
        @(negedge clk);
        data_s = d; pk_s = pk; en_s = en;
        @(negedge clk);
        check({tag, " R4 R9 model"}, corr_s, ref_o);
    endtask

    // flip one position of 0..63 data, 64.. full check index
    task automatic flip(inout data_t d, inout chk_t ck, input int pos);
        if (pos < 64) d[pos] = ~d[pos];
        else ck[pos-64] = ~ck[pos-64];
    endtask

    initial begin
        data_t d, dd, orig;
        chk_t  ck, en;
        data_s = rnd_data();
        repeat (3) @(negedge clk);
        check("R9 reset", corr_s, '0);
        rst = 1'b0;

        // R5: all lines on, up to two errors
        en = '1;
        for (int n = 0; n < 240; n++) begin
            int p1 = $urandom_range(95);
            int p2 = $urandom_range(95);
            orig = rnd_data();
            dd = orig;
            ck = b_encode(orig);
            if (n % 3 >= 1) flip(dd, ck, p1);
            if (n % 3 == 2 && p2 != p1) flip(dd, ck, p2);
            run_vec(dd, b_pack(ck, en, '0), en, "R5 R1 R3");
            check("R5 original", corr_s, orig);
        end

        // R6 and R2: one group off (last, then a middle one), junk above packed bits
        for (int v = 0; v < 2; v++) begin
            en = (v == 0) ? 32'h00FF_FFFF : 32'hFF00_FFFF;
            for (int n = 0; n < 80; n++) begin
                int p = $urandom_range(87);
                orig = rnd_data();
                dd = orig;
                ck = b_encode(orig);
                if (p < 64) flip(dd, ck, p);
                else begin
                    int idx = p - 64;
                    if (v == 1 && idx >= 16) idx += 8;
                    flip(dd, ck, idx + 64);
                end
                run_vec(dd, b_pack(ck, en, $urandom()), en, "R6 R2");
                check("R6 R2 original", corr_s, orig);
            end
        end

        // R7: all lines off
        en = '0;
        for (int n = 0; n < 20; n++) begin
            d = rnd_data();
            run_vec(d, $urandom(), en, "R7");
            check("R7 passthrough", corr_s, d);
        end

        // R8: group 0 only, tie keeps received bit
        en = 32'h0000_00FF;
        for (int n = 0; n < 20; n++) begin
            orig = rnd_data();
            ck = b_encode(orig);
            ck[n % 8] = ~ck[n % 8];
            run_vec(orig, b_pack(ck, en, $urandom()), en, "R8 check flip");
            check("R8 check flip keeps data", corr_s, orig);
            dd = orig;
            dd[n] = ~dd[n];
            run_vec(dd, b_pack(b_encode(orig), en, '0), en, "R8 data flip");
            check("R8 data flip kept", corr_s, dd);
        end

        // R9: reset in mid run clears output
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R9 mid reset", corr_s, '0);
        rst = 1'b0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule